// File: doc/BRIEF.md
# ATA strobe timing generator

This block produces the read and write strobe waveforms for one parallel ATA channel. A single packed 32-bit timing word supplies all phase lengths. It holds one group of fields for data transfers (PIO and multiword DMA) and a second group for task-file register accesses. A select input picks the group when a transfer starts.

Each transfer has three phases. It begins with a setup phase, in which both strobes stay high. The selected strobe then goes low for the active phase. After that comes a recovery phase, in which both strobes are high again. Every field value N gives a phase of N+1 clock cycles. The setup phase belongs only to the first cycle. If the continue input is high at the end of recovery, the next cycle goes straight into another active phase with the same settings. A one-cycle done pulse marks the last recovery cycle of every strobe cycle.

The controller that drives the block supplies the start pulse, the direction, the field group and the word. The timing word is taken in only when a start is accepted, so the word may change freely while a transfer is running.

Top module: `ata_strobe_gen`

## Requirements
- R1: After reset, and whenever no transfer is running, both strobe outputs are high (1) and done is low.
- R2: A start is accepted only when the block is idle. The setup phase that follows lasts S+1 cycles with both strobes high. S is bits 24:22 of the word for a data transfer (cmd_sel_i=0) and bits 27:25 for a task-file access (cmd_sel_i=1).
- R3: For a data transfer, the active phase lasts A+1 cycles, where A is bits 8:4 of the word.
- R4: For a data transfer, the recovery phase lasts H+1 cycles with both strobes high, where H is bits 3:0 of the word.
- R5: For a task-file access, the active phase lasts bits 17:13 plus one cycles and the recovery phase lasts bits 12:9 plus one cycles.
- R6: Only the selected strobe goes low. The read strobe is used when rd_sel_i=1 and the write strobe when rd_sel_i=0. Both strobes are never low at the same time.
- R7: done is high for exactly one cycle, the last cycle of each recovery phase.
- R8: If cont_i is high in the last recovery cycle, the next cycle starts a new active phase with no setup phase, using the held settings. Otherwise the block returns to idle.
- R9: The word, direction and field-group inputs are sampled only when a start is accepted. A start pulse or an input change during a transfer has no effect on the waveform.
- R10: Bits 31:28 of the word have no effect on the strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a transfer (taken when idle) |
| cont_i | input | 1 | Chain another strobe cycle after recovery |
| rd_sel_i | input | 1 | 1 = read strobe, 0 = write strobe |
| cmd_sel_i | input | 1 | 1 = task-file field group, 0 = data field group |
| timing_i | input | 32 | Packed timing word |
| rd_strobe_n_o | output | 1 | Read strobe, active low |
| wr_strobe_n_o | output | 1 | Write strobe, active low |
| done_o | output | 1 | One-cycle pulse on the last recovery cycle |

## Verification
On every cycle the assertions check the following:
- The two strobes are never low together.
- done lasts one cycle and falls only while both strobes are high.
- A done with continue set leads directly into a strobe-low cycle.
- A done without continue leads to idle.

The phase lengths per field group cannot be shown by a property. The same holds for the missing setup on chained cycles, the ignored upper bits and the sampling of inputs at acceptance. The bench shows these by comparing a behavioural model cycle by cycle while it changes the word, direction and start input in the middle of transfers.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;
   localparam int CNT_W = 5;

   // field positions inside the packed timing word
   localparam int DAT_REC_LSB = 0;
   localparam int DAT_REC_W   = 4;
   localparam int DAT_ACT_LSB = 4;
   localparam int DAT_ACT_W   = 5;
   localparam int CMD_REC_LSB = 9;
   localparam int CMD_REC_W   = 4;
   localparam int CMD_ACT_LSB = 13;
   localparam int CMD_ACT_W   = 5;
   localparam int DAT_SET_LSB = 22;
   localparam int DAT_SET_W   = 3;
   localparam int CMD_SET_LSB = 25;
   localparam int CMD_SET_W   = 3;
   localparam int TIMING_TOP  = 28;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_SETUP   = 2'd1,
      PH_ACTIVE  = 2'd2,
      PH_RECOVER = 2'd3
   } phase_e;

   typedef struct packed {
      logic [CNT_W-1:0] setup;
      logic [CNT_W-1:0] active;
      logic [CNT_W-1:0] recover;
   } phase_set_t;
endpackage

// File: rtl/ata_timing_decode.sv
module ata_timing_decode
   import ata_strobe_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic              cmd_sel_i,
   output phase_set_t        set_o
);
   generate
      if (WORD_W < TIMING_TOP) begin : g_bad_width
         $error("ata_timing_decode: WORD_W too small for the field layout");
      end
   endgenerate

   function automatic logic [CNT_W-1:0] pick(input logic [WORD_W-1:0] w,
                                             input int lsb, input int width);
      logic [WORD_W-1:0] sh;
      logic [CNT_W-1:0]  msk;
      sh  = w >> lsb;
      msk = CNT_W'((1 << width) - 1);
      return sh[CNT_W-1:0] & msk;
   endfunction

   // upper option bits play no part in strobe timing
   logic unused_top;
   assign unused_top = ^word_i[WORD_W-1:TIMING_TOP];

   always_comb begin
      if (cmd_sel_i) begin
         set_o.setup   = pick(word_i, CMD_SET_LSB, CMD_SET_W);
         set_o.active  = pick(word_i, CMD_ACT_LSB, CMD_ACT_W);
         set_o.recover = pick(word_i, CMD_REC_LSB, CMD_REC_W);
      end else begin
         set_o.setup   = pick(word_i, DAT_SET_LSB, DAT_SET_W);
         set_o.active  = pick(word_i, DAT_ACT_LSB, DAT_ACT_W);
         set_o.recover = pick(word_i, DAT_REC_LSB, DAT_REC_W);
      end
   end
endmodule

// File: rtl/ata_phase_counter.sv
module ata_phase_counter #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= load_val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ata_phase_fsm.sv
module ata_phase_fsm
   import ata_strobe_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cont_i,
   input  logic             cnt_zero_i,
   input  logic [CNT_W-1:0] live_setup_i,
   input  phase_set_t       held_i,
   output phase_e           phase_o,
   output logic             load_o,
   output logic [CNT_W-1:0] load_val_o
);
   phase_e phase_q, phase_d;

   always_comb begin
      phase_d    = phase_q;
      load_o     = 1'b0;
      load_val_o = '0;
      unique case (phase_q)
         PH_IDLE: if (start_i) begin
            phase_d    = PH_SETUP;
            load_o     = 1'b1;
            load_val_o = live_setup_i;
         end
         PH_SETUP: if (cnt_zero_i) begin
            phase_d    = PH_ACTIVE;
            load_o     = 1'b1;
            load_val_o = held_i.active;
         end
         PH_ACTIVE: if (cnt_zero_i) begin
            phase_d    = PH_RECOVER;
            load_o     = 1'b1;
            load_val_o = held_i.recover;
         end
         PH_RECOVER: if (cnt_zero_i) begin
            if (cont_i) begin
               phase_d    = PH_ACTIVE;
               load_o     = 1'b1;
               load_val_o = held_i.active;
            end else begin
               phase_d = PH_IDLE;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign phase_o = phase_q;
endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
   import ata_strobe_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int N_LANES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cont_i,
   input  logic              rd_sel_i,
   input  logic              cmd_sel_i,
   input  logic [WORD_W-1:0] timing_i,
   output logic              rd_strobe_n_o,
   output logic              wr_strobe_n_o,
   output logic              done_o
);
   generate
      if (N_LANES != 2) begin : g_bad_lanes
         $error("ata_strobe_gen: exactly two strobe lanes are supported");
      end
   endgenerate

   phase_set_t       live_set, held_q;
   logic             rd_q;
   phase_e           phase;
   logic             load, cnt_zero, accept;
   logic [CNT_W-1:0] load_val;
   logic [N_LANES-1:0] strobe_n;

   ata_timing_decode #(.WORD_W(WORD_W)) u_decode (
      .word_i    (timing_i),
      .cmd_sel_i (cmd_sel_i),
      .set_o     (live_set)
   );

   assign accept = (phase == PH_IDLE) && start_i;

   // keep only the decoded phase lengths, not the whole word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         rd_q   <= 1'b0;
      end else if (accept) begin
         held_q <= live_set;
         rd_q   <= rd_sel_i;
      end
   end

   ata_phase_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .cont_i       (cont_i),
      .cnt_zero_i   (cnt_zero),
      .live_setup_i (live_set.setup),
      .held_i       (held_q),
      .phase_o      (phase),
      .load_o       (load),
      .load_val_o   (load_val)
   );

   ata_phase_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (load_val),
      .zero_o     (cnt_zero)
   );

   // lane 0 = read strobe, lane 1 = write strobe
   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      localparam logic LANE_IS_RD = (i == 0);
      assign strobe_n[i] = !((phase == PH_ACTIVE) && (rd_q == LANE_IS_RD));
   end

   assign rd_strobe_n_o = strobe_n[0];
   assign wr_strobe_n_o = strobe_n[1];
   assign done_o        = (phase == PH_RECOVER) && cnt_zero;
endmodule

// File: rtl/ata_strobe_chk.sv
module ata_strobe_chk (
   input logic clk,
   input logic rst_n,
   input logic cont_i,
   input logic rd_n,
   input logic wr_n,
   input logic done
);
   a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n || wr_n));

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_done_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rd_n && wr_n));

   a_r8_chain_active: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cont_i) |=> (!rd_n || !wr_n));

   a_r1_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cont_i) |=> (rd_n && wr_n && !done));
endmodule

bind ata_strobe_gen ata_strobe_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cont_i (cont_i),
   .rd_n   (rd_strobe_n_o),
   .wr_n   (wr_strobe_n_o),
   .done   (done_o)
);

// File: tb/ata_strobe_gen_bench.sv
module ata_strobe_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, cont = 1'b0, rdsel = 1'b0, cmdsel = 1'b0;
   logic [31:0] tword = '0;
   logic        rd_n, wr_n, done;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit running = 0;

   always #5 clk = ~clk;

   ata_strobe_gen u_ata_strobe_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cont_i(cont),
      .rd_sel_i(rdsel), .cmd_sel_i(cmdsel), .timing_i(tword),
      .rd_strobe_n_o(rd_n), .wr_strobe_n_o(wr_n), .done_o(done)
   );

   // behavioural reference: phase 0 idle, 1 setup, 2 active, 3 recovery
   int       m_ph = 0, m_left = 0, m_act = 0, m_rec = 0;
   bit       m_rd = 0, m_chain = 0, m_top = 0;
   bit       m_cmd = 0;
   logic [31:0] m_word = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph <= 0; m_left <= 0; m_chain <= 0;
      end else begin
         case (m_ph)
            0: if (start) begin
               m_word <= tword; m_rd <= rdsel; m_cmd <= cmdsel;
               m_top  <= (tword[31:28] != 0);
               m_act  <= cmdsel ? int'(tword[17:13]) : int'(tword[8:4]);
               m_rec  <= cmdsel ? int'(tword[12:9])  : int'(tword[3:0]);
               m_left <= cmdsel ? int'(tword[27:25]) : int'(tword[24:22]);
               m_ph <= 1; m_chain <= 0;
            end
            1: if (m_left == 0) begin m_ph <= 2; m_left <= m_act; end
               else m_left <= m_left - 1;
            2: if (m_left == 0) begin m_ph <= 3; m_left <= m_rec; end
               else m_left <= m_left - 1;
            default: if (m_left == 0) begin
               if (cont) begin m_ph <= 2; m_left <= m_act; m_chain <= 1; end
               else m_ph <= 0;
            end else m_left <= m_left - 1;
         endcase
      end
   end

   function automatic string tag_of();
      string t;
      case (m_ph)
         0: t = "R1";
         1: t = "R2";
         2: t = m_cmd ? "R5" : "R3";
         default: t = m_cmd ? "R5" : "R4";
      endcase
      if (m_chain) t = {t, "/R8"};
      if (m_ph != 0 && (tword != m_word || rdsel != m_rd || start)) t = {t, "/R9"};
      if (m_ph != 0 && m_top) t = {t, "/R10"};
      return t;
   endfunction

   always @(negedge clk) begin
      if (running) begin
         bit e_rd, e_wr, e_done;
         e_rd   = !(m_ph == 2 && m_rd);
         e_wr   = !(m_ph == 2 && !m_rd);
         e_done = (m_ph == 3 && m_left == 0);
         checks++;
         if (rd_n !== e_rd || wr_n !== e_wr) begin
            fails++;
            $display("FAIL %s/R6 strobes rd_n=%b wr_n=%b expected rd_n=%b wr_n=%b at cycle %0d",
                     tag_of(), rd_n, wr_n, e_rd, e_wr, cycles);
         end
         checks++;
         if (done !== e_done) begin
            fails++;
            $display("FAIL %s/R7 done=%b expected %b at cycle %0d",
                     tag_of(), done, e_done, cycles);
         end
      end
   end

   always @(posedge clk) cycles++;

   initial begin
      wait (cycles > 150000);
      fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   function automatic logic [31:0] mk(input int dh, dl, ch, cl, pre, cpre, top);
      return {4'(top), 3'(cpre), 3'(pre), 4'd0, 5'(cl), 4'(ch), 5'(dl), 4'(dh)};
   endfunction

   // one transfer of 'bursts' chained strobe cycles; disturbs inputs mid-way (R9)
   task automatic xfer(input logic [31:0] w, input bit rd, input bit cmd, input int bursts);
      int seen = 0;
      int k = 0;
      @(negedge clk);
      tword = w; rdsel = rd; cmdsel = cmd; start = 1'b1; cont = (bursts > 1);
      @(negedge clk);
      start = 1'b0; tword = ~w; rdsel = ~rd; cmdsel = ~cmd;
      forever begin
         if (done) begin seen++; cont = (seen < bursts); end
         if (seen >= bursts) break;
         start = (k == 3);
         k++;
         @(negedge clk);
      end
      start = 1'b0; cont = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (rd_n !== 1'b1 || wr_n !== 1'b1 || done !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset rd_n=%b wr_n=%b done=%b expected 1 1 0", rd_n, wr_n, done);
      end
      rst_n = 1'b1;
      running = 1;
      repeat (2) @(negedge clk);
      xfer(mk(2, 3, 1, 1, 1, 0, 0), 1, 0, 1);      // R3 R4 data read
      xfer(mk(0, 0, 0, 0, 0, 0, 0), 0, 0, 1);      // minimum lengths, write
      xfer(mk(15, 31, 0, 0, 7, 0, 0), 1, 0, 1);    // maximum data fields
      xfer(mk(1, 1, 3, 6, 2, 5, 0), 0, 1, 1);      // R5 task-file write
      xfer(mk(9, 9, 15, 31, 0, 7, 0), 1, 1, 1);    // R5 max command fields
      xfer(mk(3, 2, 0, 0, 4, 0, 0), 1, 0, 4);      // R8 chained reads
      xfer(mk(0, 4, 2, 3, 0, 3, 0), 0, 1, 3);      // R8 chained command writes
      xfer(mk(2, 5, 1, 2, 3, 1, 15), 0, 0, 2);     // R10 top bits set
      xfer(mk(2, 5, 1, 2, 3, 1, 0), 0, 0, 2);      // R10 same without top bits
      repeat (5) @(negedge clk);                   // R1 idle afterwards
      running = 0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule